// File: doc/BRIEF.md
# Filtered Input Capture Channel

This block is one capture channel of a timer. An asynchronous input passes through a two-stage synchronizer and then a run-length glitch filter. The filter takes on a new level only after a programmed number of consecutive samples have shown that level. An edge detector then picks rising or falling transitions of the filtered level as valid events. An event divider turns every 1st, 2nd, 4th or 8th valid event into a capture.

A capture copies the timer count into the capture register and raises the capture flag. A capture that arrives while the flag is still raised also raises the overcapture flag. Software lowers the capture flag with a clear strobe or a read strobe, and lowers the overcapture flag with its own clear strobe. A software strobe can raise the capture flag directly. The filtered level and the selected edge pulse are brought out so that neighbouring logic, such as a slave-mode controller, can use them as a trigger.

Top module: `icap_channel`

## Requirements
- R1: `filt_level` resets to 0 and changes to the synchronized input level only after `filt_len` consecutive samples at the new level; `filt_len` = 0 acts as 1. Any sample equal to the current `filt_level` restarts the run. With `filt_len` = N, a change of `sig_in` held from clock edge k is shown on `filt_level` after edge k+1+N.
- R2: `filt_edge` is high for exactly the one cycle in which `filt_level` first shows a new level. It responds to 0-to-1 changes when `edge_fall` = 0 and to 1-to-0 changes when `edge_fall` = 1.
- R3: `evt_div` selects how many valid edges make one capture: 0 = every edge, 1 = every 2nd, 2 = every 4th, 3 = every 8th. The edge count restarts from zero while `cap_en` is low.
- R4: On a capture, at the next clock edge `cap_value` takes the `count_val` present in the cycle where `filt_edge` was high, and `cap_flag` is set. `cap_value` holds otherwise.
- R5: A capture in a cycle where `cap_flag` is already 1 sets `ovr_flag` at the next clock edge.
- R6: `clr_cap_flag` or `cap_read` clears `cap_flag` at the next edge, unless a capture or `sw_cap` occurs in the same cycle, in which case setting wins. Only `clr_ovr_flag` clears `ovr_flag`, and a simultaneous overcapture wins.
- R7: `sw_cap` sets `cap_flag` at the next edge. It leaves `cap_value` and `ovr_flag` unchanged.
- R8: While `rst_n` is low at a clock edge, `cap_value`, `cap_flag`, `ovr_flag`, `filt_level` and `filt_edge` all become 0.
- R9: While `cap_en` is low, no capture occurs: `cap_value` and `ovr_flag` hold, and `cap_flag` is affected only by `sw_cap` and the clear strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 1 | Asynchronous input being measured |
| count_val | input | CNT_W | Timer count to be captured |
| filt_len | input | FILT_W | Consecutive samples needed to accept a level (0 acts as 1) |
| edge_fall | input | 1 | 0: rising edges valid, 1: falling edges valid |
| evt_div | input | 2 | Valid-edge divider select (1, 2, 4, 8) |
| cap_en | input | 1 | Enables captures; low restarts the edge divider |
| sw_cap | input | 1 | Software strobe that sets the capture flag |
| clr_cap_flag | input | 1 | Strobe that clears the capture flag |
| cap_read | input | 1 | Read strobe for the capture register; clears the capture flag |
| clr_ovr_flag | input | 1 | Strobe that clears the overcapture flag |
| cap_value | output | CNT_W | Captured count |
| cap_flag | output | 1 | Capture flag |
| ovr_flag | output | 1 | Overcapture flag |
| filt_level | output | 1 | Filtered input level |
| filt_edge | output | 1 | One-cycle pulse on a selected edge of the filtered level |

## Verification
Two pairs of actions can land in the same cycle: a capture together with a flag clear, and a capture together with a still-raised capture flag, which is the overcapture case. The bench holds the clear or read strobes high across a window that contains a filtered edge, so the capture cycle meets the clear. It also lets edges arrive while the flag is still raised, with and without a simultaneous overcapture clear. A behavioural model with set-over-clear priority judges the flags in every cycle.

// File: rtl/icap_pkg.sv
// Shared definitions for the filtered input capture channel.
// Assumes the event divider never exceeds eight events per capture.
package icap_pkg;

    // Divider select encodings
    typedef enum logic [1:0] {
        EVT_DIV1 = 2'd0,
        EVT_DIV2 = 2'd1,
        EVT_DIV4 = 2'd2,
        EVT_DIV8 = 2'd3
    } evt_div_e;

    localparam int DIV_CNT_W = 3;

    // Last count value of the event divider for a given select
    function automatic logic [DIV_CNT_W-1:0] div_last(input logic [1:0] sel);
        logic [DIV_CNT_W:0] span;
        span = (DIV_CNT_W+1)'(1) << sel;
        return DIV_CNT_W'(span - (DIV_CNT_W+1)'(1));
    endfunction

endpackage

// File: rtl/icap_filter.sv
// Synchronizes an asynchronous input with two flops, then accepts a new
// level only after a programmed run of consecutive samples at that level.
// Emits one-cycle rise/fall pulses in the cycle the accepted level changes.
// Assumes filt_len is static while a run is being counted (changes apply
// to the next comparison).
module icap_filter #(
    parameter int FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_in,
    input  logic [FILT_W-1:0] filt_len,
    output logic              level,
    output logic              rise_pulse,
    output logic              fall_pulse
);
    localparam int RUN_W = FILT_W + 1;

    logic [1:0]        sync_q;
    logic              sample;
    logic [FILT_W-1:0] run_q;
    logic [RUN_W-1:0]  run_inc;
    logic [RUN_W-1:0]  needed;
    logic              differs;
    logic              accept;

    // Two-stage synchronizer for the asynchronous input
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[0], raw_in};
    end

    assign sample  = sync_q[1];
    assign differs = (sample != level);
    assign run_inc = {1'b0, run_q} + RUN_W'(1);
    assign needed  = (filt_len == '0) ? RUN_W'(1) : {1'b0, filt_len};
    assign accept  = differs && (run_inc >= needed);

    // Run-length counter and accepted level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            level <= 1'b0;
        end else if (!differs || accept) begin
            run_q <= '0;
            if (accept) level <= sample;
        end else begin
            run_q <= run_inc[FILT_W-1:0];
        end
    end

    // Edge pulses aligned with the level update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_pulse <= 1'b0;
            fall_pulse <= 1'b0;
        end else begin
            rise_pulse <= accept &&  sample;
            fall_pulse <= accept && !sample;
        end
    end

endmodule

// File: rtl/icap_divider.sv
// Counts valid edges and flags the one that completes a group of 1, 2, 4
// or 8. The count is held at zero while the channel is disabled.
// Assumes the select is changed only while the channel is disabled.
module icap_divider
    import icap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       edge_ok,
    input  logic [1:0] div_sel,
    output logic       fire
);
    logic [DIV_CNT_W-1:0] ev_cnt_q;
    logic [DIV_CNT_W-1:0] last;
    logic                 at_last;

    assign last    = div_last(div_sel);
    assign at_last = (ev_cnt_q == last);
    assign fire    = enable && edge_ok && at_last;

    // Edge counter, wraps after the last edge of each group
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) ev_cnt_q <= '0;
        else if (edge_ok)      ev_cnt_q <= at_last ? '0 : ev_cnt_q + DIV_CNT_W'(1);
    end

endmodule

// File: rtl/icap_latch.sv
// Holds the captured count plus the capture and overcapture flags.
// Setting has priority over clearing for both flags.
// Assumes all strobes are single-cycle or level inputs sampled each edge.
module icap_latch #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_cap,
    input  logic             sw_cap,
    input  logic [CNT_W-1:0] count_val,
    input  logic             clr_flag,
    input  logic             rd_strobe,
    input  logic             clr_ovr,
    output logic [CNT_W-1:0] value,
    output logic             flag,
    output logic             ovr
);
    // Captured count
    always_ff @(posedge clk) begin
        if (!rst_n)      value <= '0;
        else if (hw_cap) value <= count_val;
    end

    // Capture flag: hardware or software set, clear or read clears
    always_ff @(posedge clk) begin
        if (!rst_n)                  flag <= 1'b0;
        else if (hw_cap || sw_cap)   flag <= 1'b1;
        else if (clr_flag || rd_strobe) flag <= 1'b0;
    end

    // Overcapture flag: capture over an unserviced flag
    always_ff @(posedge clk) begin
        if (!rst_n)              ovr <= 1'b0;
        else if (hw_cap && flag) ovr <= 1'b1;
        else if (clr_ovr)        ovr <= 1'b0;
    end

endmodule

// File: rtl/icap_channel.sv
// One filtered input capture channel: synchronizer and glitch filter,
// polarity-selected edge, event divider and capture register with flags.
// Assumes count_val is synchronous to clk.
module icap_channel #(
    parameter int CNT_W  = 16,
    parameter int FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sig_in,
    input  logic [CNT_W-1:0]  count_val,
    input  logic [FILT_W-1:0] filt_len,
    input  logic              edge_fall,
    input  logic [1:0]        evt_div,
    input  logic              cap_en,
    input  logic              sw_cap,
    input  logic              clr_cap_flag,
    input  logic              cap_read,
    input  logic              clr_ovr_flag,
    output logic [CNT_W-1:0]  cap_value,
    output logic              cap_flag,
    output logic              ovr_flag,
    output logic              filt_level,
    output logic              filt_edge
);
    logic rise_pulse;
    logic fall_pulse;
    logic cap_fire;

    icap_filter #(.FILT_W(FILT_W)) u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_in     (sig_in),
        .filt_len   (filt_len),
        .level      (filt_level),
        .rise_pulse (rise_pulse),
        .fall_pulse (fall_pulse)
    );

    // Polarity selection of the filtered edge
    assign filt_edge = edge_fall ? fall_pulse : rise_pulse;

    icap_divider u_divider (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (cap_en),
        .edge_ok (filt_edge),
        .div_sel (evt_div),
        .fire    (cap_fire)
    );

    icap_latch #(.CNT_W(CNT_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_cap    (cap_fire),
        .sw_cap    (sw_cap),
        .count_val (count_val),
        .clr_flag  (clr_cap_flag),
        .rd_strobe (cap_read),
        .clr_ovr   (clr_ovr_flag),
        .value     (cap_value),
        .flag      (cap_flag),
        .ovr       (ovr_flag)
    );

endmodule

// File: rtl/icap_channel_chk.sv
// Property checker for icap_channel, attached by bind.
module icap_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cap_fire,
    input logic             rise_pulse,
    input logic             fall_pulse,
    input logic             sw_cap,
    input logic             clr_cap_flag,
    input logic             cap_read,
    input logic             clr_ovr_flag,
    input logic [CNT_W-1:0] count_val,
    input logic [CNT_W-1:0] cap_value,
    input logic             cap_flag,
    input logic             ovr_flag,
    input logic             filt_level
);
    AST_FIRE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> cap_flag); // R4
    AST_FIRE_TAKES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> (cap_value == $past(count_val))); // R4
    AST_VALUE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_fire |=> $stable(cap_value)); // R4
    AST_OVERCAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_fire && cap_flag) |=> ovr_flag); // R5
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_fire && !sw_cap && (clr_cap_flag || cap_read)) |=> !cap_flag); // R6
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !clr_ovr_flag) |=> ovr_flag); // R6
    AST_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        sw_cap |=> cap_flag); // R7
    AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_pulse, fall_pulse})); // R2
    AST_RISE_MATCHES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |-> filt_level); // R2
endmodule

bind icap_channel icap_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cap_fire     (cap_fire),
    .rise_pulse   (rise_pulse),
    .fall_pulse   (fall_pulse),
    .sw_cap       (sw_cap),
    .clr_cap_flag (clr_cap_flag),
    .cap_read     (cap_read),
    .clr_ovr_flag (clr_ovr_flag),
    .count_val    (count_val),
    .cap_value    (cap_value),
    .cap_flag     (cap_flag),
    .ovr_flag     (ovr_flag),
    .filt_level   (filt_level)
);

// File: tb/tb_icap_channel.sv
`timescale 1ns/1ps
module tb_icap_channel;
    localparam int CNT_W  = 16;
    localparam int FILT_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sig_in = 1'b0;
    logic [CNT_W-1:0]  count_val = '0;
    logic [FILT_W-1:0] filt_len = '0;
    logic              edge_fall = 1'b0;
    logic [1:0]        evt_div = 2'd0;
    logic              cap_en = 1'b0;
    logic              sw_cap = 1'b0;
    logic              clr_cap_flag = 1'b0;
    logic              cap_read = 1'b0;
    logic              clr_ovr_flag = 1'b0;
    logic [CNT_W-1:0]  cap_value;
    logic              cap_flag, ovr_flag, filt_level, filt_edge;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    icap_channel #(.CNT_W(CNT_W), .FILT_W(FILT_W)) dut (.*);

    always #5 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    logic             hist[$];
    int               run_len = 0;
    int               ev_seen = 0;
    logic             m_lvl = 0, m_rise = 0, m_fall = 0;
    logic             m_flag = 0, m_ovr = 0;
    logic [CNT_W-1:0] m_val = '0;
    bit               started = 0;

    always @(posedge clk) begin
        logic smp, sel, fire;
        int   need, group;
        started = 1;
        if (!rst_n) begin
            hist = '{1'b0, 1'b0};
            run_len = 0; ev_seen = 0;
            m_lvl = 0; m_rise = 0; m_fall = 0;
            m_flag = 0; m_ovr = 0; m_val = '0;
        end else begin
            smp = hist[1];
            hist.push_front(sig_in);
            void'(hist.pop_back());
            sel   = edge_fall ? m_fall : m_rise;
            group = 1 << evt_div;
            fire  = 0;
            if (!cap_en) ev_seen = 0;
            else if (sel) begin
                ev_seen = ev_seen + 1;
                if (ev_seen == group) begin fire = 1; ev_seen = 0; end
                else if (ev_seen >= 8) ev_seen = 0;
            end
            if (fire && m_flag) m_ovr = 1;
            else if (clr_ovr_flag) m_ovr = 0;
            if (fire || sw_cap) m_flag = 1;
            else if (clr_cap_flag || cap_read) m_flag = 0;
            if (fire) m_val = count_val;
            need = (filt_len == 0) ? 1 : int'(filt_len);
            m_rise = 0; m_fall = 0;
            if (smp == m_lvl) run_len = 0;
            else begin
                run_len = run_len + 1;
                if (run_len >= need) begin
                    m_lvl = smp; run_len = 0;
                    m_rise = smp; m_fall = !smp;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (started && !finished) begin
            check(filt_level === m_lvl, rst_n ? "R1 filt_level" : "R8 filt_level", filt_level, m_lvl);
            check(filt_edge === (edge_fall ? m_fall : m_rise), rst_n ? "R2 filt_edge" : "R8 filt_edge",
                  filt_edge, edge_fall ? m_fall : m_rise);
            check(cap_value === m_val, rst_n ? "R4 cap_value" : "R8 cap_value", cap_value, m_val);
            check(cap_flag === m_flag, rst_n ? "R6 cap_flag" : "R8 cap_flag", cap_flag, m_flag);
            check(ovr_flag === m_ovr, rst_n ? "R5 ovr_flag" : "R8 ovr_flag", ovr_flag, m_ovr);
        end
        count_val <= count_val + CNT_W'(3);
    end

    task automatic hold(input logic v, input int n);
        sig_in = v;
        repeat (n) @(negedge clk);
    endtask

    // Count captures over a pulse train with reads held high (R3)
    task automatic div_phase(input logic [1:0] sel, input int edges, input int expect_caps);
        int seen;
        cap_en = 0; @(negedge clk);
        evt_div = sel; cap_read = 1; cap_en = 1; seen = 0;
        for (int i = 0; i < edges; i++) begin
            sig_in = 1;
            repeat (4) begin @(negedge clk); if (cap_flag) seen++; end
            sig_in = 0;
            repeat (4) begin @(negedge clk); if (cap_flag) seen++; end
        end
        repeat (4) begin @(negedge clk); if (cap_flag) seen++; end
        check(seen == expect_caps, "R3 capture count", seen, expect_caps);
        cap_read = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cap_value == 0 && !cap_flag && !ovr_flag && !filt_level && !filt_edge,
              "R8 reset state", {cap_flag, ovr_flag, filt_level}, 0);
        rst_n = 1;
        // R1/R4: filter length 3, glitches rejected, long pulse accepted
        filt_len = 3; cap_en = 1;
        hold(1, 2); hold(0, 5);
        check(!filt_level && !cap_flag, "R1 glitch rejected", filt_level, 0);
        hold(1, 8);
        check(filt_level && cap_flag, "R1 level accepted", {filt_level, cap_flag}, 3);
        hold(0, 8);
        // R5: second rise while flag still set
        hold(1, 8);
        check(ovr_flag, "R5 overcapture", ovr_flag, 1);
        hold(0, 6);
        // R6: read clears capture flag, ovr persists until its clear
        cap_read = 1; @(negedge clk); cap_read = 0; @(negedge clk);
        check(!cap_flag && ovr_flag, "R6 read clears flag only", {cap_flag, ovr_flag}, 1);
        clr_ovr_flag = 1; @(negedge clk); clr_ovr_flag = 0; @(negedge clk);
        check(!ovr_flag, "R6 ovr cleared", ovr_flag, 0);
        // R6: capture during a held clear strobe (set wins)
        clr_cap_flag = 1; hold(1, 8); clr_cap_flag = 0; hold(0, 6);
        // R5/R6: overcapture while clearing ovr in the same window
        sw_cap = 1; @(negedge clk); sw_cap = 0;
        clr_ovr_flag = 1; hold(1, 8); clr_ovr_flag = 0; hold(0, 6);
        // R7: software strobe with clear in the same cycle
        clr_cap_flag = 1; @(negedge clk); clr_cap_flag = 0;
        sw_cap = 1; clr_cap_flag = 1; @(negedge clk); sw_cap = 0; clr_cap_flag = 0;
        @(negedge clk);
        check(cap_flag, "R7 sw strobe sets flag", cap_flag, 1);
        // R1: length 8, seven-sample glitch rejected
        filt_len = 8;
        hold(1, 7); hold(0, 10);
        check(!filt_level, "R1 seven-sample glitch", filt_level, 0);
        hold(1, 12); hold(0, 12);
        // R2: falling polarity
        edge_fall = 1; cap_read = 1; @(negedge clk); cap_read = 0;
        filt_len = 2;
        hold(1, 6); hold(0, 6); hold(1, 6);
        // R9: disabled channel ignores edges
        cap_en = 0; clr_cap_flag = 1; clr_ovr_flag = 1; @(negedge clk);
        clr_cap_flag = 0; clr_ovr_flag = 0;
        hold(0, 6); hold(1, 6); hold(0, 6);
        check(!cap_flag && !ovr_flag, "R9 disabled no capture", {cap_flag, ovr_flag}, 0);
        // R3: divider groups, rising edges, length 0 acts as 1
        edge_fall = 0; filt_len = 0;
        div_phase(2'd0, 4, 4);
        div_phase(2'd1, 4, 2);
        div_phase(2'd2, 8, 2);
        div_phase(2'd3, 8, 1);
        // R3: disabling mid-group restarts the count
        cap_en = 0; @(negedge clk); evt_div = 2'd1; cap_en = 1;
        hold(1, 4); hold(0, 4);
        cap_en = 0; @(negedge clk); cap_en = 1;
        hold(1, 4); hold(0, 6);
        check(!cap_flag, "R3 restart after disable", cap_flag, 0);
        // R8: reset mid-run
        hold(1, 3); rst_n = 0; @(negedge clk); @(negedge clk);
        check(cap_value == 0 && !cap_flag && !filt_level, "R8 reset clears", cap_value, 0);
        rst_n = 1; hold(0, 6);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule